// File: doc/BRIEF.md
# Windowed Device Aperture Bridge

This block sits between a 16-bit host processor bus and a set of addressable devices. The processor sees one fixed data aperture of 4096 addresses. Two selector registers choose what the aperture points at. One register picks which device is targeted. The other picks which 4096-address window inside that device is visible. Each aperture access becomes a flat device-bus transaction carrying the device ID, a 28-bit device address, write data, a chip enable and a write enable.

Device IDs are split into two ranges. The low range is steered to a framework port and the rest to a core port. Each port reports whether some device claims the current ID, returns read data, and may request a stall.

The host side uses a valid/ready handshake. The host holds `cpu_valid` together with its address, write flag and write data until a cycle in which `cpu_ready` is high. That cycle completes the access, and for a read `cpu_rdata` is valid in that same cycle. `cpu_ready` drops only when an aperture access targets a claimed device that asserts wait, so back-pressure comes from the selected device alone. Selector register writes take effect from the cycle after they complete.

Top module: `aperture_bridge`

## Requirements
- R1: A completed write to host address 0xFFF4 loads the 16-bit device-ID register, and a completed write to 0xFFF5 loads the 16-bit window register. The new value applies to the next access, and a read of either address returns the register's current value.
- R2: After reset both selector registers hold 0.
- R3: A valid host access to any address from 0x7000 to 0x7FFF raises chip enable on the selected port. A write also raises that port's write enable and drives `cpu_wdata` onto `dev_wdata`.
- R4: The device address is `{window, cpu_addr[11:0]}`, which equals window × 4096 plus (host address − 0x7000). Window 3 with host address 0x7012 gives 0x0003012, and window 0xFFFF with 0x7FFF gives 0xFFFFFFF.
- R5: IDs 0x0000 to 0x00FF select the framework port and IDs 0x0100 to 0xFFFF select the core port. At most one port has chip enable in any cycle.
- R6: `dev_id` always shows the ID register and changes only after a write to 0xFFF4. With no aperture access in progress, both chip enables are low.
- R7: While the selected port claims the ID and asserts wait during an aperture access, `cpu_ready` stays low. The access completes in the first cycle in which wait is low.
- R8: An aperture read whose selected port does not claim the ID returns 0xEEEE and completes at once, even if that port asserts wait.
- R9: Neither write enable is raised by accesses outside the aperture, including writes to 0xFFF4 and 0xFFF5.
- R10: A read from any other address outside the aperture and the two selectors returns 0x0000 and completes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Host access request |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_addr | input | 16 | Host word address |
| cpu_we | input | 1 | Access is a write |
| cpu_wdata | input | 16 | Host write data |
| cpu_rdata | output | 16 | Host read data, valid when cpu_ready |
| dev_id | output | 16 | Currently selected device ID |
| dev_addr | output | 28 | Window and offset within the device |
| dev_wdata | output | 16 | Write data toward the devices |
| fw_ce | output | 1 | Framework port chip enable |
| fw_we | output | 1 | Framework port write enable |
| fw_rdata | input | 16 | Framework port read data |
| fw_claim | input | 1 | A framework device decodes dev_id |
| fw_wait | input | 1 | Framework device stall request |
| core_ce | output | 1 | Core port chip enable |
| core_we | output | 1 | Core port write enable |
| core_rdata | input | 16 | Core port read data |
| core_claim | input | 1 | A core device decodes dev_id |
| core_wait | input | 1 | Core device stall request |

## Verification
The bench targets these corner cases:
- **Top window with the last aperture word.** A design that sliced the window too narrowly would wrap the 28-bit address.
- **The 0x00FF/0x0100 routing split.** The bench uses IDs on both sides of it, so an off-by-one compare would steer an access to the wrong port.
- **Selector writes.** A bridge that leaked write enable on a selector write would corrupt device memory, and the bench checks for this.
- **Multi-cycle stall.** A design that ignored wait would finish early. The bench compares the exact number of stalled cycles.
- **Unclaimed ID with wait asserted.** A design that honoured wait from an unclaimed port would hang or delay instead of returning 0xEEEE.

// File: rtl/aperture_pkg.sv
package aperture_pkg;
  typedef enum logic [1:0] {
    TGT_OTHER,
    TGT_ID_REG,
    TGT_WIN_REG,
    TGT_APERTURE
  } cpu_target_e;
endpackage

// File: rtl/aperture_selregs.sv
module aperture_selregs #(
  parameter int ID_W  = 16,
  parameter int WIN_W = 16,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_id,
  input  logic             load_win,
  input  logic [BUS_W-1:0] wdata,
  output logic [ID_W-1:0]  id_q,
  output logic [WIN_W-1:0] win_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q  <= '0;
      win_q <= '0;
    end else begin
      if (load_id)  id_q  <= wdata[ID_W-1:0];
      if (load_win) win_q <= wdata[WIN_W-1:0];
    end
  end
endmodule

// File: rtl/aperture_route.sv
module aperture_route #(
  parameter int          ID_W     = 16,
  parameter logic [15:0] ID_SPLIT = 16'h0100
) (
  input  logic [ID_W-1:0] id_q,
  input  logic            access,
  input  logic            write,
  output logic            to_core,
  output logic            fw_ce,
  output logic            fw_we,
  output logic            core_ce,
  output logic            core_we
);
  always_comb begin
    to_core = (id_q >= ID_W'(ID_SPLIT));
    fw_ce   = access && !to_core;
    core_ce = access && to_core;
    fw_we   = fw_ce && write;
    core_we = core_ce && write;
  end
endmodule

// File: rtl/aperture_rdmux.sv
module aperture_rdmux
  import aperture_pkg::*;
#(
  parameter int          BUS_W  = 16,
  parameter int          ID_W   = 16,
  parameter int          WIN_W  = 16,
  parameter logic [15:0] MARKER = 16'hEEEE
) (
  input  cpu_target_e      tgt,
  input  logic             to_core,
  input  logic [ID_W-1:0]  id_q,
  input  logic [WIN_W-1:0] win_q,
  input  logic [BUS_W-1:0] fw_rdata,
  input  logic             fw_claim,
  input  logic             fw_wait,
  input  logic [BUS_W-1:0] core_rdata,
  input  logic             core_claim,
  input  logic             core_wait,
  output logic [BUS_W-1:0] rdata,
  output logic             stall
);
  logic             sel_claim;
  logic             sel_wait;
  logic [BUS_W-1:0] sel_rdata;

  always_comb begin
    sel_claim = to_core ? core_claim : fw_claim;
    sel_wait  = to_core ? core_wait  : fw_wait;
    sel_rdata = to_core ? core_rdata : fw_rdata;
    stall     = 1'b0;
    rdata     = '0;
    case (tgt)
      TGT_ID_REG:  rdata = BUS_W'(id_q);
      TGT_WIN_REG: rdata = BUS_W'(win_q);
      TGT_APERTURE: begin
        if (sel_claim) begin
          rdata = sel_rdata;
          stall = sel_wait;
        end else begin
          rdata = BUS_W'(MARKER);
        end
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/aperture_bridge.sv
module aperture_bridge
  import aperture_pkg::*;
#(
  parameter int          BUS_W     = 16,
  parameter int          CPU_AW    = 16,
  parameter int          OFF_W     = 12,
  parameter int          ID_W      = 16,
  parameter int          WIN_W     = 16,
  parameter logic [15:0] APER_BASE = 16'h7000,
  parameter logic [15:0] ID_ADDR   = 16'hFFF4,
  parameter logic [15:0] WIN_ADDR  = 16'hFFF5,
  parameter logic [15:0] ID_SPLIT  = 16'h0100,
  parameter logic [15:0] MARKER    = 16'hEEEE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_valid,
  output logic                   cpu_ready,
  input  logic [CPU_AW-1:0]      cpu_addr,
  input  logic                   cpu_we,
  input  logic [BUS_W-1:0]       cpu_wdata,
  output logic [BUS_W-1:0]       cpu_rdata,
  output logic [ID_W-1:0]        dev_id,
  output logic [WIN_W+OFF_W-1:0] dev_addr,
  output logic [BUS_W-1:0]       dev_wdata,
  output logic                   fw_ce,
  output logic                   fw_we,
  input  logic [BUS_W-1:0]       fw_rdata,
  input  logic                   fw_claim,
  input  logic                   fw_wait,
  output logic                   core_ce,
  output logic                   core_we,
  input  logic [BUS_W-1:0]       core_rdata,
  input  logic                   core_claim,
  input  logic                   core_wait
);
  localparam int PAGE_W = CPU_AW - OFF_W;

  cpu_target_e      tgt;
  logic [ID_W-1:0]  id_q;
  logic [WIN_W-1:0] win_q;
  logic             to_core;
  logic             stall;
  logic             done_wr;

  always_comb begin
    if (cpu_addr[CPU_AW-1:OFF_W] == APER_BASE[CPU_AW-1:OFF_W]) tgt = TGT_APERTURE;
    else if (cpu_addr == CPU_AW'(ID_ADDR))                      tgt = TGT_ID_REG;
    else if (cpu_addr == CPU_AW'(WIN_ADDR))                     tgt = TGT_WIN_REG;
    else                                                        tgt = TGT_OTHER;
  end

  assign cpu_ready = !stall;
  assign done_wr   = cpu_valid && cpu_ready && cpu_we;
  assign dev_id    = id_q;
  assign dev_addr  = {win_q, cpu_addr[OFF_W-1:0]};
  assign dev_wdata = cpu_wdata;

  aperture_selregs #(.ID_W(ID_W), .WIN_W(WIN_W), .BUS_W(BUS_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_id  (done_wr && tgt == TGT_ID_REG),
    .load_win (done_wr && tgt == TGT_WIN_REG),
    .wdata    (cpu_wdata),
    .id_q     (id_q),
    .win_q    (win_q)
  );

  aperture_route #(.ID_W(ID_W), .ID_SPLIT(ID_SPLIT)) u_route (
    .id_q    (id_q),
    .access  (cpu_valid && tgt == TGT_APERTURE),
    .write   (cpu_we),
    .to_core (to_core),
    .fw_ce   (fw_ce),
    .fw_we   (fw_we),
    .core_ce (core_ce),
    .core_we (core_we)
  );

  aperture_rdmux #(.BUS_W(BUS_W), .ID_W(ID_W), .WIN_W(WIN_W), .MARKER(MARKER)) u_rdmux (
    .tgt        (tgt),
    .to_core    (to_core),
    .id_q       (id_q),
    .win_q      (win_q),
    .fw_rdata   (fw_rdata),
    .fw_claim   (fw_claim),
    .fw_wait    (fw_wait),
    .core_rdata (core_rdata),
    .core_claim (core_claim),
    .core_wait  (core_wait),
    .rdata      (cpu_rdata),
    .stall      (stall)
  );

  logic unused_page;
  assign unused_page = ^PAGE_W;
endmodule

// File: rtl/aperture_bridge_chk.sv
module aperture_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_valid,
  input logic        cpu_ready,
  input logic [15:0] cpu_addr,
  input logic        cpu_we,
  input logic [15:0] dev_id,
  input logic [27:0] dev_addr,
  input logic        fw_ce,
  input logic        fw_we,
  input logic        core_ce,
  input logic        core_we,
  input logic        fw_claim,
  input logic        fw_wait,
  input logic        core_claim,
  input logic        core_wait
);
  AST_CE_IN_APERTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_ce || core_ce) |-> (cpu_valid && cpu_addr[15:12] == 4'h7)); // R3
  AST_OFFSET_PASSED: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_ce || core_ce) |-> (dev_addr[11:0] == cpu_addr[11:0])); // R4
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fw_ce, core_ce})); // R5
  AST_CORE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    core_ce |-> (dev_id >= 16'h0100)); // R5
  AST_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_valid && cpu_ready && cpu_we && cpu_addr == 16'hFFF4) |=> $stable(dev_id)); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_ce && core_claim && core_wait) || (fw_ce && fw_claim && fw_wait)) |-> !cpu_ready); // R7
  AST_NO_STRAY_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_addr[15:12] != 4'h7) |-> !(fw_we || core_we)); // R9
endmodule

bind aperture_bridge aperture_bridge_chk u_chk (.*);

// File: tb/sim_aperture_bridge.sv
module sim_aperture_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_ready;
  logic [15:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic [15:0] dev_id;
  logic [27:0] dev_addr;
  logic [15:0] dev_wdata;
  logic        fw_ce, fw_we, core_ce, core_we;
  logic [15:0] fw_rdata, core_rdata;
  logic        fw_claim, fw_wait, core_claim, core_wait;

  int errors = 0;
  int checks = 0;
  int stall_seen = 0;
  int stall_used = 0;
  int stall_lim = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic [15:0] rd;
    bit          chk_rd;
    logic [27:0] da;
    bit          chk_da;
    bit          e_fw;
    bit          e_core;
    bit          e_we;
    logic [15:0] wd;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  // device models
  assign fw_claim   = (dev_id == 16'h0002);
  assign core_claim = (dev_id >= 16'h0100) && (dev_id <= 16'h0107);
  assign fw_rdata   = {dev_addr[11:0], 4'h9};
  assign core_rdata = dev_addr[15:0] ^ 16'hA5C3;
  assign fw_wait    = 1'b0;
  assign core_wait  = core_ce && (stall_used < stall_lim);
  always @(posedge clk) if (core_wait) stall_used <= stall_used + 1;

  aperture_bridge u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when an access completes
  always @(negedge clk) begin
    if (cpu_valid && !cpu_ready) stall_seen <= stall_seen + 1;
    if (cpu_valid && cpu_ready) begin
      if (sb.size() == 0) begin
        check("scoreboard empty", 0, 1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.chk_rd) check({e.tag, " rdata"}, 32'(cpu_rdata), 32'(e.rd));
        if (e.chk_da) check({e.tag, " dev_addr"}, 32'(dev_addr), 32'(e.da));
        check({e.tag, " ce"}, {30'd0, fw_ce, core_ce}, {30'd0, e.e_fw, e.e_core});
        check({e.tag, " we"}, {30'd0, fw_we, core_we},
              {30'd0, e.e_we && e.e_fw, e.e_we && e.e_core});
        if (e.e_we && (e.e_fw || e.e_core)) check({e.tag, " wdata"}, 32'(dev_wdata), 32'(e.wd));
      end
    end
  end

  task automatic acc(input logic [15:0] a, input bit w, input logic [15:0] d,
                     input logic [15:0] rd, input bit chk_rd,
                     input logic [27:0] da, input bit chk_da,
                     input bit e_fw, input bit e_core, input string tag);
    exp_t e;
    e = '{tag, rd, chk_rd, da, chk_da, e_fw, e_core, w, d};
    sb.push_back(e);
    @(posedge clk); #1;
    cpu_valid = 1'b1; cpu_addr = a; cpu_we = w; cpu_wdata = d;
    do @(negedge clk); while (!cpu_ready);
    @(posedge clk); #1;
    cpu_valid = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d, input string tag);
    acc(a, 1'b1, d, 16'h0, 1'b0, 28'h0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    int s0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R2 dev_id after reset", 32'(dev_id), 0);
    check("R6 idle ce after reset", {30'd0, fw_ce, core_ce}, 0);
    acc(16'hFFF4, 0, 0, 16'h0000, 1, 0, 0, 0, 0, "R2 id read");
    acc(16'hFFF5, 0, 0, 16'h0000, 1, 0, 0, 0, 0, "R2 win read");
    wr(16'hFFF4, 16'h0100, "R9 id write no we");
    wr(16'hFFF5, 16'h0003, "R9 win write no we");
    acc(16'hFFF4, 0, 0, 16'h0100, 1, 0, 0, 0, 0, "R1 id readback");
    acc(16'hFFF5, 0, 0, 16'h0003, 1, 0, 0, 0, 0, "R1 win readback");
    acc(16'h7012, 0, 0, 16'h3012 ^ 16'hA5C3, 1, 28'h0003012, 1, 0, 1, "R4 R5 core read");
    acc(16'h7ABC, 1, 16'h1234, 0, 0, 28'h0003ABC, 1, 0, 1, "R3 core write");
    @(negedge clk);
    check("R6 id held idle", 32'(dev_id), 32'h0100);
    check("R6 no ce idle", {30'd0, fw_ce, core_ce}, 0);
    wr(16'hFFF4, 16'h0002, "R1 set fw id");
    wr(16'hFFF5, 16'h0000, "R1 set win 0");
    acc(16'h7005, 0, 0, 16'h0059, 1, 28'h0000005, 1, 1, 0, "R5 fw read");
    acc(16'h7006, 1, 16'hBEEF, 0, 0, 28'h0000006, 1, 1, 0, "R3 fw write");
    wr(16'hFFF4, 16'h00FF, "R5 set top fw id");
    acc(16'h7000, 0, 0, 16'hEEEE, 1, 0, 0, 1, 0, "R8 R5 unclaimed fw 0x00FF");
    wr(16'hFFF4, 16'h0200, "R5 set unclaimed core id");
    s0 = stall_seen;
    stall_lim = stall_used + 2;
    acc(16'h7001, 0, 0, 16'hEEEE, 1, 0, 0, 0, 1, "R8 unclaimed core with wait");
    check("R8 no stall on unclaimed", stall_seen - s0, 0);
    stall_lim = 0;
    wr(16'hFFF4, 16'h0105, "R1 set core id");
    wr(16'hFFF5, 16'hFFFF, "R1 set top window");
    acc(16'h7FFF, 0, 0, 16'hFFFF ^ 16'hA5C3, 1, 28'hFFFFFFF, 1, 0, 1, "R4 top window");
    s0 = stall_seen;
    stall_lim = stall_used + 3;
    acc(16'h7010, 0, 0, 16'hF010 ^ 16'hA5C3, 1, 28'hFFFF010, 1, 0, 1, "R7 stalled read");
    check("R7 stall cycles", stall_seen - s0, 3);
    stall_lim = 0;
    acc(16'h1234, 0, 0, 16'h0000, 1, 0, 0, 0, 0, "R10 other read");
    acc(16'h8000, 1, 16'h5555, 0, 0, 0, 0, 0, 0, "R9 write outside aperture");
    acc(16'hFFF4, 0, 0, 16'h0105, 1, 0, 0, 0, 0, "R9 id unchanged");
    repeat (2) @(posedge clk);
    check("scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule